// File: doc/BRIEF.md
# Clock-Gate Power Controller

This block holds the run/stop state of the clock gates for a group of on-chip peripherals. The gates are split into three banks of up to 32 gates. Bank 2 serves analog and PHY power domains. Each gate drives one bit of a clock-enable output, and a 1 on that bit lets the clock run. Software reaches the block through a small register bus. Each write is taken in one cycle, and each read returns its data one cycle after the request.

A static parameter picks one of two programming models. In the strobe model, every bank has three words: a status word, a word that switches gates on, and a word that switches gates off. The on and off words act only on the bits written as 1, so no read-modify-write is needed. In the legacy model, software rewrites a whole control word per bank, and a 1 in that word means "powered down". Only banks 0 and 1 can be reached in the legacy model.

The clock-enable output follows a request at once. The status bit confirms the change only after a programmable acknowledge delay, so software polls status until it reads the state it asked for.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: Reset, whether at power-up or asynchronous in mid-run, sets every clock-enable bit to 1. After reset, every status word in the strobe model reads 0xFFFFFFFF.
- R2: In the strobe model, a write to bank b at address 0x24+0x10*b turns on the gates whose data bits are 1. Gates whose data bits are 0 stay as they were.
- R3: In the strobe model, a write to bank b at address 0x28+0x10*b turns off the gates whose data bits are 1. Gates whose data bits are 0 stay as they were.
- R4: A clock-enable bit changes on the first clock edge after the write that changes it is accepted. In a cycle without an accepted write, no clock-enable bit changes.
- R5: A gate's status bit takes its new state ACK_DLY clock edges after the edge that accepted the write (default 4). Until then it keeps the old state. In the strobe model, status of bank b is at 0x20+0x10*b, and a bit reads 1 when the gate runs.
- R6: A request that changes a gate while an earlier change to that gate is still pending restarts the gate's delay, counted from the newest request. The status bit ends at the newest requested state.
- R7: Reads of the on and off strobe words return 0. Reads of unmapped addresses return 0, for example 0x04, and 0x30 in the legacy model.
- R8: A read request raises rsp_vld for exactly one cycle, in the cycle after the request, with the data in that same cycle. rsp_vld stays low in every other cycle.
- R9: In the legacy model, control words sit at 0x1C (bank 0) and 0x24 (bank 1), and status words at 0x20 and 0x28. In all four words a 1 means powered down. A control write sets every gate of its bank to the inverse of the written word. The control word reads back the requested state. Bank 2 stays running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_vld | input | 1 | Register request valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | WIDTH | Write data |
| rsp_vld | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | WIDTH | Read data |
| clk_en | output | BANKS*WIDTH | Gate enables; bank b occupies bits b*WIDTH upward, and 1 means running |

## Verification
The bench reads status back to back around the acknowledge boundary. It expects the old value in the read sampled at edge ACK_DLY and the new value one edge later, so a delay off by one cycle in either direction shows up as a mismatch. It sends off, on, off requests to one gate within three cycles. A design that keeps its first countdown instead of restarting would show the gate stopped several cycles too early. It writes masks with zero bits and checks that their neighbours survive, which catches a strobe that overwrites the whole word. It also checks the inverted sense of the legacy words and that bank 2 is left alone, which catches a legacy path that forgets the inversion or reaches the analog bank.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

  // read source selected by the address decoder
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_STAT = 2'd1,
    SRC_CTRL = 2'd2
  } rd_src_e;

  // strobe model: per-bank window of three words
  localparam int NEW_BASE   = 'h20;
  localparam int NEW_STRIDE = 'h10;
  localparam int OFS_STAT   = 'h0;
  localparam int OFS_ON     = 'h4;
  localparam int OFS_OFF    = 'h8;

  // legacy model: two interleaved control/status pairs
  localparam int LEG_CTRL0  = 'h1C;
  localparam int LEG_STAT0  = 'h20;
  localparam int LEG_STRIDE = 'h08;
  localparam int LEG_BANKS  = 2;

endpackage

// File: rtl/pgc_decode.sv
module pgc_decode
  import pgc_pkg::*;
#(
  parameter int BANKS  = 3,
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8,
  parameter bit LEGACY = 1'b0,
  localparam int BW    = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [WIDTH-1:0]             wdata,
  output logic [BANKS-1:0][WIDTH-1:0]  set_m,
  output logic [BANKS-1:0][WIDTH-1:0]  clr_m,
  output rd_src_e                      rd_src,
  output logic [BW-1:0]                rd_bank
);

  int a;
  assign a = int'(addr);

  always_comb begin
    set_m   = '0;
    clr_m   = '0;
    rd_src  = SRC_NONE;
    rd_bank = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (!LEGACY) begin
        if (a == NEW_BASE + b*NEW_STRIDE + OFS_STAT) begin
          rd_src  = SRC_STAT;
          rd_bank = BW'(b);
        end
        if (wr_en && (a == NEW_BASE + b*NEW_STRIDE + OFS_ON))
          set_m[b] = wdata;
        if (wr_en && (a == NEW_BASE + b*NEW_STRIDE + OFS_OFF))
          clr_m[b] = wdata;
      end else if (b < LEG_BANKS) begin
        if (a == LEG_CTRL0 + b*LEG_STRIDE) begin
          rd_src  = SRC_CTRL;
          rd_bank = BW'(b);
          if (wr_en) begin
            clr_m[b] = wdata;
            set_m[b] = ~wdata;
          end
        end
        if (a == LEG_STAT0 + b*LEG_STRIDE) begin
          rd_src  = SRC_STAT;
          rd_bank = BW'(b);
        end
      end
    end
  end

endmodule

// File: rtl/pgc_bank.sv
module pgc_bank #(
  parameter int WIDTH   = 32,
  parameter int ACK_DLY = 4,
  localparam int CW     = $clog2(ACK_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_m,
  input  logic [WIDTH-1:0] clr_m,
  output logic [WIDTH-1:0] run,
  output logic [WIDTH-1:0] stat
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_gate
    logic          req_q, req_d;
    logic          ack_q, ack_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          tgt, upd;

    always_comb begin
      tgt   = set_m[i] ? 1'b1 : (clr_m[i] ? 1'b0 : req_q);
      req_d = tgt;
      ack_d = ack_q;
      cnt_d = cnt_q;
      if (tgt != req_q) begin
        cnt_d = CW'(ACK_DLY);
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - CW'(1);
        if (cnt_q == CW'(1)) ack_d = req_q;
      end
      upd = (tgt != req_q) || (cnt_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q <= 1'b1;
        ack_q <= 1'b1;
        cnt_q <= '0;
      end else if (upd) begin
        req_q <= req_d;
        ack_q <= ack_d;
        cnt_q <= cnt_d;
      end
    end

    assign run[i]  = req_q;
    assign stat[i] = ack_q;
  end

endmodule

// File: rtl/pgc_readback.sv
module pgc_readback
  import pgc_pkg::*;
#(
  parameter int BANKS  = 3,
  parameter int WIDTH  = 32,
  parameter bit LEGACY = 1'b0,
  localparam int BW    = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  rd_src_e                      rd_src,
  input  logic [BW-1:0]                rd_bank,
  input  logic [BANKS-1:0][WIDTH-1:0]  run,
  input  logic [BANKS-1:0][WIDTH-1:0]  stat,
  output logic                         rsp_vld,
  output logic [WIDTH-1:0]             rsp_rdata
);

  logic [WIDTH-1:0] data_d, data_q;
  logic             vld_q;
  logic [WIDTH-1:0] run_sel, stat_sel;

  always_comb begin
    run_sel  = '0;
    stat_sel = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (int'(rd_bank) == b) begin
        run_sel  = run[b];
        stat_sel = stat[b];
      end
    end
    unique case (rd_src)
      SRC_STAT: data_d = LEGACY ? ~stat_sel : stat_sel;
      SRC_CTRL: data_d = ~run_sel;
      default:  data_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (rd_en) data_q <= data_d;
  end

  assign rsp_vld   = vld_q;
  assign rsp_rdata = data_q;

endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
  import pgc_pkg::*;
#(
  parameter int BANKS   = 3,
  parameter int WIDTH   = 32,
  parameter int ADDR_W  = 8,
  parameter int ACK_DLY = 4,
  parameter bit LEGACY  = 1'b0,
  localparam int BW     = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_vld,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [WIDTH-1:0]       bus_wdata,
  output logic                   rsp_vld,
  output logic [WIDTH-1:0]       rsp_rdata,
  output logic [BANKS*WIDTH-1:0] clk_en
);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic                         wr_en, rd_en;
  logic [BANKS-1:0][WIDTH-1:0]  set_m, clr_m, run_w, stat_w;
  logic [BANKS*WIDTH-1:0]       stat_flat;
  rd_src_e                      rd_src;
  logic [BW-1:0]                rd_bank;

  assign wr_en = bus_vld && bus_wr;
  assign rd_en = bus_vld && !bus_wr;

  pgc_decode #(
    .BANKS(BANKS), .WIDTH(WIDTH), .ADDR_W(ADDR_W), .LEGACY(LEGACY)
  ) u_decode (
    .wr_en  (wr_en),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .set_m  (set_m),
    .clr_m  (clr_m),
    .rd_src (rd_src),
    .rd_bank(rd_bank)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    pgc_bank #(.WIDTH(WIDTH), .ACK_DLY(ACK_DLY)) u_bank (
      .clk  (clk),
      .rst_n(rst_q),
      .set_m(set_m[b]),
      .clr_m(clr_m[b]),
      .run  (run_w[b]),
      .stat (stat_w[b])
    );
  end

  pgc_readback #(
    .BANKS(BANKS), .WIDTH(WIDTH), .LEGACY(LEGACY)
  ) u_readback (
    .clk      (clk),
    .rst_n    (rst_q),
    .rd_en    (rd_en),
    .rd_src   (rd_src),
    .rd_bank  (rd_bank),
    .run      (run_w),
    .stat     (stat_w),
    .rsp_vld  (rsp_vld),
    .rsp_rdata(rsp_rdata)
  );

  assign clk_en    = run_w;
  assign stat_flat = stat_w;

endmodule

// File: rtl/pgc_chk.sv
module pgc_chk #(
  parameter int BANKS  = 3,
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_vld,
  input logic                   bus_wr,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   rsp_vld,
  input logic [WIDTH-1:0]       rsp_rdata,
  input logic [BANKS*WIDTH-1:0] run,
  input logic [BANKS*WIDTH-1:0] stat
);

  // R4
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_vld && bus_wr) |=> $stable(run));

  // R5
  stat_toward_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat ^ $past(stat)) & (stat ^ run)) == '0);

  // R8
  rsp_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && !bus_wr) |=> rsp_vld);

  // R8
  rsp_only_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_vld && !bus_wr) |=> !rsp_vld);

  // R7
  hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && !bus_wr && bus_addr == ADDR_W'(4)) |=> (rsp_rdata == '0));

endmodule

bind pwr_gate_ctrl pgc_chk #(
  .BANKS(BANKS), .WIDTH(WIDTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .bus_vld  (bus_vld),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .rsp_vld  (rsp_vld),
  .rsp_rdata(rsp_rdata),
  .run      (clk_en),
  .stat     (stat_flat)
);

// File: tb/pwr_gate_ctrl_test.sv
module pwr_gate_ctrl_test;

  localparam int ACK = 4;
  localparam int NV  = 16;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;   // write data, or expected read data
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t TBL [0:NV-1] = '{
    '{1'b0, 8'h20, 32'hFFFF_FFFF, 4'd1},  // R1 bank0 status after reset
    '{1'b0, 8'h30, 32'hFFFF_FFFF, 4'd1},  // R1
    '{1'b0, 8'h40, 32'hFFFF_FFFF, 4'd1},  // R1
    '{1'b1, 8'h28, 32'h0000_00F0, 4'd3},  // R3 bank0 off bits 7:4
    '{1'b0, 8'h20, 32'hFFFF_FF0F, 4'd3},
    '{1'b1, 8'h24, 32'h0000_0030, 4'd2},  // R2 bank0 on bits 5:4
    '{1'b0, 8'h20, 32'hFFFF_FF3F, 4'd2},
    '{1'b1, 8'h48, 32'h8000_0001, 4'd3},  // R3 bank2
    '{1'b0, 8'h40, 32'h7FFF_FFFE, 4'd3},
    '{1'b0, 8'h24, 32'h0000_0000, 4'd7},  // R7 strobe word reads 0
    '{1'b0, 8'h48, 32'h0000_0000, 4'd7},  // R7
    '{1'b0, 8'h04, 32'h0000_0000, 4'd7},  // R7 hole
    '{1'b1, 8'h38, 32'hFFFF_FFFF, 4'd3},  // R3 bank1 all off
    '{1'b0, 8'h30, 32'h0000_0000, 4'd3},
    '{1'b1, 8'h34, 32'h0000_FFFF, 4'd2},  // R2 bank1 low half on
    '{1'b0, 8'h30, 32'h0000_FFFF, 4'd2}
  };

  logic        clk, rst_n;
  logic        vld_a, vld_b, wr;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic        rsp_vld_a, rsp_vld_b;
  logic [31:0] rdata_a, rdata_b;
  logic [95:0] en_a, en_b;

  int n_cmp = 0;
  int n_bad = 0;

  pwr_gate_ctrl #(.ACK_DLY(ACK), .LEGACY(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .bus_vld(vld_a), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .rsp_vld(rsp_vld_a), .rsp_rdata(rdata_a), .clk_en(en_a)
  );

  pwr_gate_ctrl #(.ACK_DLY(ACK), .LEGACY(1'b1)) uut_leg (
    .clk(clk), .rst_n(rst_n), .bus_vld(vld_b), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .rsp_vld(rsp_vld_b), .rsp_rdata(rdata_b), .clk_en(en_b)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [95:0] act,
                     input logic [95:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive one cycle from a falling edge, return at the next falling edge
  task automatic step(input bit sel, input bit v, input bit w,
                      input logic [7:0] a, input logic [31:0] d);
    vld_a = v & ~sel;
    vld_b = v & sel;
    wr    = w;
    addr  = a;
    wdata = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 8'h00, 32'h0);
  endtask

  task automatic rd_chk(input bit sel, input logic [7:0] a,
                        input logic [31:0] exp, input string tag);
    step(sel, 1'b1, 1'b0, a, 32'h0);
    if (sel) chk(rsp_vld_b && rdata_b == exp, tag, {64'h0, rdata_b}, {64'h0, exp});
    else     chk(rsp_vld_a && rdata_a == exp, tag, {64'h0, rdata_a}, {64'h0, exp});
    vld_a = 1'b0;
    vld_b = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    vld_a = 1'b0; vld_b = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R1 enables are on while reset is held
    chk(en_a == '1, "R1", en_a, '1);
    rst_n = 1'b1;
    idle(4);

    // table walk: strobe model
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) begin
        step(1'b0, 1'b1, 1'b1, TBL[i].addr, TBL[i].data);
      end else begin
        rd_chk(1'b0, TBL[i].addr, TBL[i].data, $sformatf("R%0d", TBL[i].rq));
      end
      idle(ACK + 2);
    end
    // R2 R3 masks left neighbours untouched
    chk(en_a == {32'h7FFF_FFFE, 32'h0000_FFFF, 32'hFFFF_FF3F}, "R2_R3",
        en_a, {32'h7FFF_FFFE, 32'h0000_FFFF, 32'hFFFF_FF3F});

    // R4 R5 R8: acknowledge timing, bank0 bit0 off
    step(1'b0, 1'b1, 1'b1, 8'h28, 32'h1);
    chk(en_a[0] == 1'b0, "R4", {95'h0, en_a[0]}, 96'h0);
    for (int k = 1; k <= ACK + 2; k++) begin
      logic [31:0] exp;
      step(1'b0, 1'b1, 1'b0, 8'h20, 32'h0);
      exp = (k >= ACK + 1) ? 32'hFFFF_FF3E : 32'hFFFF_FF3F;
      chk(rsp_vld_a && rdata_a == exp, $sformatf("R5 k=%0d", k),
          {64'h0, rdata_a}, {64'h0, exp});
    end
    step(1'b0, 1'b0, 1'b0, 8'h00, 32'h0);
    chk(!rsp_vld_a, "R8", {95'h0, rsp_vld_a}, 96'h0);
    idle(ACK + 2);

    // R6: off, idle, on, off on bank2 bit1
    step(1'b0, 1'b1, 1'b1, 8'h48, 32'h2);   // E0
    step(1'b0, 1'b0, 1'b0, 8'h00, 32'h0);   // E1
    step(1'b0, 1'b1, 1'b1, 8'h44, 32'h2);   // E2
    step(1'b0, 1'b1, 1'b1, 8'h48, 32'h2);   // E3
    for (int k = 4; k <= 8; k++) begin
      logic [31:0] exp;
      step(1'b0, 1'b1, 1'b0, 8'h40, 32'h0);
      exp = (k == 8) ? 32'h7FFF_FFFC : 32'h7FFF_FFFE;
      chk(rsp_vld_a && rdata_a == exp, $sformatf("R6 k=%0d", k),
          {64'h0, rdata_a}, {64'h0, exp});
    end
    vld_a = 1'b0;
    idle(ACK + 2);

    // R9 legacy model
    rd_chk(1'b1, 8'h1C, 32'h0, "R9 ctrl0 reset");
    rd_chk(1'b1, 8'h20, 32'h0, "R9 stat0 reset");
    step(1'b1, 1'b1, 1'b1, 8'h1C, 32'h0000_0100);
    vld_b = 1'b0;
    chk(en_b[8] == 1'b0, "R9 gate off", {95'h0, en_b[8]}, 96'h0);
    idle(ACK + 2);
    rd_chk(1'b1, 8'h20, 32'h0000_0100, "R9 stat0");
    rd_chk(1'b1, 8'h1C, 32'h0000_0100, "R9 ctrl0");
    step(1'b1, 1'b1, 1'b1, 8'h24, 32'h0000_000F);
    vld_b = 1'b0;
    idle(ACK + 2);
    rd_chk(1'b1, 8'h28, 32'h0000_000F, "R9 stat1");
    step(1'b1, 1'b1, 1'b1, 8'h1C, 32'h0);
    vld_b = 1'b0;
    idle(ACK + 2);
    rd_chk(1'b1, 8'h20, 32'h0, "R9 stat0 back on");
    chk(en_b == {32'hFFFF_FFFF, 32'hFFFF_FFF0, 32'hFFFF_FFFF}, "R9 bank2 untouched",
        en_b, {32'hFFFF_FFFF, 32'hFFFF_FFF0, 32'hFFFF_FFFF});
    rd_chk(1'b1, 8'h30, 32'h0, "R7 legacy hole");

    // R1 reset in mid-run
    rst_n = 1'b0;
    idle(2);
    chk(en_a == '1, "R1 mid-run", en_a, '1);
    rst_n = 1'b1;
    idle(4);
    rd_chk(1'b0, 8'h20, 32'hFFFF_FFFF, "R1 stat0");
    rd_chk(1'b0, 8'h40, 32'hFFFF_FFFF, "R1 stat2");

    summary();
    $finish;
  end

endmodule